// File: doc/BRIEF.md
# Ethernet-to-DMA Receive Channel Router

This block sits on the receive path between several Ethernet receive channels and a larger set of DMA receive channels. Each incoming packet descriptor names the Ethernet channel it came from. The router gives every Ethernet channel its own window of DMA channels, described by a base channel and a channel count. Each Ethernet channel steps through its own window in round-robin order, one DMA channel per descriptor. The descriptor leaves the block with the chosen DMA channel attached.

Software changes a window through a small register port. Every write restarts that channel's rotation at the window base. Both fields can be read back. At reset the DMA channels are split evenly and in order among the Ethernet channels. The outgoing descriptor sits in a single output register with a valid/ready handshake, and it is held while the consumer stalls.

Top module: `eth_dma_chan_router`

## Requirements
- R1: After reset, Ethernet channel k has base k*(N_DST/N_SRC) and count N_DST/N_SRC. With the defaults of 4 sources and 32 destinations, channel k covers DMA channels 8k to 8k+7.
- R2: Successive descriptors accepted from one Ethernet channel go to base, base+1, ... up to base+count-1, then back to base.
- R3: Each Ethernet channel keeps its own rotation position. Descriptors from other channels do not move it.
- R4: A stored count of 0 behaves as a count of 1, so every descriptor from that channel goes to its base. The count reads back as 0.
- R5: A count write larger than N_DST is stored as N_DST.
- R6: A window that runs past DMA channel N_DST-1 continues at DMA channel 0. The destination is (base + position) modulo N_DST.
- R7: A write to either field of channel k restarts channel k's rotation, so its next descriptor goes to the base then in force. Other channels keep their positions.
- R8: Register address bit 0 selects the field (0 = base, 1 = count), and the bits above it select the Ethernet channel. A read strobe puts that field, zero-extended, on reg_rdata one cycle later. reg_rdata keeps that value until the next read strobe.
- R9: in_ready is high when the output register is empty or is being emptied in the same cycle. A descriptor accepted on a clock edge is presented on the outputs right after that edge. While out_valid is high and out_ready is low, the outputs do not change. Under backpressure no descriptor is lost or duplicated.
- R10: out_src and out_data equal the in_src and in_data of the same accepted descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming descriptor valid |
| in_ready | output | 1 | Router can take a descriptor |
| in_src | input | SRC_W (2) | Ethernet channel of the incoming descriptor |
| in_data | input | DATA_W (16) | Descriptor payload, passed through |
| out_valid | output | 1 | Outgoing descriptor valid |
| out_ready | input | 1 | Consumer takes the outgoing descriptor |
| out_src | output | SRC_W (2) | Ethernet channel of the outgoing descriptor |
| out_dst | output | DST_W (5) | Chosen DMA channel |
| out_data | output | DATA_W (16) | Descriptor payload |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | SRC_W+1 (3) | {channel, field} register address |
| reg_wdata | input | CNT_W (6) | Write data (the low DST_W bits are used for a base write) |
| reg_rdata | output | CNT_W (6) | Read data, one cycle after the read strobe |

## Verification
A descriptor accepted on a clock edge shows up on the outputs right after that edge. The bench therefore computes the expected DMA channel when it sees the handshake condition, queues the result, and compares it to the outputs at every later falling edge until out_ready takes it. Register reads are due one edge after the strobe, and the bench checks reg_rdata at the next falling edge. A window write changes the destination of the very next descriptor from that channel, and the bench's model applies the write on the same edge as the design does. Stalls are checked cycle by cycle: the held values must match the previous cycle, and when the bench drains the output at the end, the queue must be empty.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic {
    FLD_BASE  = 1'b0,
    FLD_COUNT = 1'b1
  } fld_e;
endpackage

// File: rtl/rtr_window_regs.sv
module rtr_window_regs
  import rtr_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int N_DST = 32,
  parameter int SRC_W = 2,
  parameter int DST_W = 5,
  parameter int CNT_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [SRC_W:0]                   addr,
  input  logic [CNT_W-1:0]                 wdata,
  output logic [CNT_W-1:0]                 rdata,
  output logic [N_SRC-1:0][DST_W-1:0]      base_q,
  output logic [N_SRC-1:0][CNT_W-1:0]      cnt_q,
  output logic [N_SRC-1:0]                 touch
);
  localparam int SLICE = N_DST / N_SRC;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N_DST);

  logic [SRC_W-1:0]                a_src;
  fld_e                            a_fld;
  logic [CNT_W-1:0]                cnt_sat;
  logic [N_SRC-1:0]                base_en, cnt_en;
  logic [N_SRC-1:0][DST_W-1:0]     base_nx;
  logic [N_SRC-1:0][CNT_W-1:0]     cnt_nx;
  logic [CNT_W-1:0]                rd_nx;

  assign a_src   = addr[SRC_W:1];
  assign a_fld   = fld_e'(addr[0]);
  assign cnt_sat = (wdata > CNT_MAX) ? CNT_MAX : wdata;

  always_comb begin
    for (int k = 0; k < N_SRC; k++) begin
      base_en[k] = wr_en && (a_src == SRC_W'(k)) && (a_fld == FLD_BASE);
      cnt_en[k]  = wr_en && (a_src == SRC_W'(k)) && (a_fld == FLD_COUNT);
      base_nx[k] = wdata[DST_W-1:0];
      cnt_nx[k]  = cnt_sat;
      touch[k]   = base_en[k] | cnt_en[k];
    end
  end

  always_comb begin
    rd_nx = '0;
    if (int'(a_src) < N_SRC) begin
      rd_nx = (a_fld == FLD_BASE) ? CNT_W'(base_q[a_src]) : cnt_q[a_src];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_SRC; k++) begin
        base_q[k] <= DST_W'(k * SLICE);
        cnt_q[k]  <= CNT_W'(SLICE);
      end
      rdata <= '0;
    end else begin
      for (int k = 0; k < N_SRC; k++) begin
        if (base_en[k]) base_q[k] <= base_nx[k];
        if (cnt_en[k])  cnt_q[k]  <= cnt_nx[k];
      end
      if (rd_en) rdata <= rd_nx;
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_chk
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[k] <= CNT_MAX);
  end

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/rtr_rr_offset.sv
module rtr_rr_offset #(
  parameter int N_SRC = 4,
  parameter int SRC_W = 2,
  parameter int CNT_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic [SRC_W-1:0]             adv_src,
  input  logic [N_SRC-1:0]             clr,
  input  logic [N_SRC-1:0][CNT_W-1:0]  cnt,
  output logic [N_SRC-1:0][CNT_W-1:0]  off_q
);
  logic [N_SRC-1:0][CNT_W-1:0] ceff, off_nx;
  logic [N_SRC-1:0]            off_en;
  logic [CNT_W-1:0]            stepv;

  always_comb begin
    stepv = '0;
    for (int k = 0; k < N_SRC; k++) begin
      ceff[k]   = (cnt[k] == '0) ? CNT_W'(1) : cnt[k];
      stepv     = off_q[k] + 1'b1;
      off_nx[k] = off_q[k];
      off_en[k] = 1'b0;
      if (clr[k]) begin
        off_nx[k] = '0;
        off_en[k] = 1'b1;
      end else if (adv && (adv_src == SRC_W'(k))) begin
        off_nx[k] = (stepv >= ceff[k]) ? '0 : stepv;
        off_en[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else begin
      for (int k = 0; k < N_SRC; k++) begin
        if (off_en[k]) off_q[k] <= off_nx[k];
      end
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_chk
    p_off_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      off_q[k] < ceff[k]);
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr[k] |=> off_q[k] == '0);
    p_other_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[k] && !(adv && adv_src == SRC_W'(k))) |=> $stable(off_q[k]));
  end
endmodule

// File: rtl/rtr_out_stage.sv
module rtr_out_stage #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_bus,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_bus
);
  logic load, v_nx;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    v_nx = out_valid;
    if (load)           v_nx = 1'b1;
    else if (out_ready) v_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v_nx;
  end

  always_ff @(posedge clk) begin
    if (load) out_bus <= in_bus;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bus)));
  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/eth_dma_chan_router.sv
module eth_dma_chan_router #(
  parameter int N_SRC  = 4,
  parameter int N_DST  = 32,
  parameter int DATA_W = 16,
  parameter int SRC_W  = $clog2(N_SRC),
  parameter int DST_W  = $clog2(N_DST),
  parameter int CNT_W  = $clog2(N_DST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SRC_W-1:0]  out_src,
  output logic [DST_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SRC_W:0]    reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  localparam int BUS_W = SRC_W + DST_W + DATA_W;
  localparam logic [CNT_W:0] NDST_X = (CNT_W+1)'(N_DST);

  logic [N_SRC-1:0][DST_W-1:0] base_q;
  logic [N_SRC-1:0][CNT_W-1:0] cnt_q, off_q;
  logic [N_SRC-1:0]            touch;
  logic [CNT_W:0]              sum;
  logic [DST_W-1:0]            dst_nx;
  logic [BUS_W-1:0]            bus_in, bus_out;
  logic                        accept;

  rtr_window_regs #(
    .N_SRC(N_SRC), .N_DST(N_DST), .SRC_W(SRC_W), .DST_W(DST_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .base_q(base_q), .cnt_q(cnt_q), .touch(touch)
  );

  assign accept = in_valid && in_ready;

  rtr_rr_offset #(
    .N_SRC(N_SRC), .SRC_W(SRC_W), .CNT_W(CNT_W)
  ) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(accept), .adv_src(in_src),
    .clr(touch), .cnt(cnt_q), .off_q(off_q)
  );

  always_comb begin
    sum    = (CNT_W+1)'(base_q[in_src]) + (CNT_W+1)'(off_q[in_src]);
    dst_nx = (sum >= NDST_X) ? DST_W'(sum - NDST_X) : DST_W'(sum);
  end

  assign bus_in = {in_src, dst_nx, in_data};

  rtr_out_stage #(.W(BUS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bus(bus_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_bus(bus_out)
  );

  assign {out_src, out_dst, out_data} = bus_out;

  p_dst_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_dst) < N_DST);
endmodule

// File: tb/sim_eth_dma_chan_router.sv
module sim_eth_dma_chan_router;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, ND = 32, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] in_src = '0;
  logic [DW-1:0] in_data = '0;
  logic [2:0] reg_addr = '0;
  logic [5:0] reg_wdata = '0;
  logic in_ready, out_valid;
  logic [1:0] out_src;
  logic [4:0] out_dst;
  logic [DW-1:0] out_data;
  logic [5:0] reg_rdata;

  eth_dma_chan_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_src(out_src), .out_dst(out_dst),
    .out_data(out_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int m_base[NS], m_cnt[NS], m_off[NS];
  logic [22:0] exp_q[$];
  string tag_q[$];
  logic hold_pend = 1'b0;
  logic [22:0] held;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dst(input int s);
    return (m_base[s] + m_off[s]) % ND;
  endfunction

  task automatic advance(input int s);
    int ce;
    ce = (m_cnt[s] == 0) ? 1 : m_cnt[s];
    m_off[s] = (m_off[s] + 1 >= ce) ? 0 : m_off[s] + 1;
  endtask

  task automatic step(input bit iv, input int s, input int d, input bit ordy, input string tag);
    logic [22:0] cur;
    in_valid = iv; in_src = 2'(s); in_data = DW'(d); out_ready = ordy;
    #1;
    cur = {out_src, out_dst, out_data};
    if (hold_pend) check(out_valid && cur == held, "R9 hold under stall", int'(cur), int'(held));
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected output", int'(cur), -1);
      end else begin
        check(out_dst == exp_q[0][20:16], {tag_q[0], " dst"}, int'(out_dst), int'(exp_q[0][20:16]));
        check({out_src, out_data} == {exp_q[0][22:21], exp_q[0][15:0]}, "R10 src/data",
              int'({out_src, out_data}), int'({exp_q[0][22:21], exp_q[0][15:0]}));
        if (ordy) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
      end
    end
    hold_pend = out_valid && !ordy;
    held = cur;
    if (iv && in_ready) begin
      exp_q.push_back({2'(s), 5'(exp_dst(s)), DW'(d)});
      tag_q.push_back(tag);
      advance(s);
    end
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input int s, input int fld, input int val);
    reg_wr = 1'b1; reg_addr = {2'(s), 1'(fld)}; reg_wdata = 6'(val);
    if (fld == 0) m_base[s] = val % ND;
    else          m_cnt[s]  = (val > ND) ? ND : val;
    m_off[s] = 0;
    step(0, 0, 0, 1'b1, "R7");
  endtask

  task automatic rd_reg(input int s, input int fld, input string tag);
    int e;
    reg_rd = 1'b1; reg_addr = {2'(s), 1'(fld)};
    step(0, 0, 0, 1'b1, tag);
    e = (fld == 0) ? m_base[s] : m_cnt[s];
    check(int'(reg_rdata) == e, {tag, " readback"}, int'(reg_rdata), e);
  endtask

  task automatic drain(input string tag);
    repeat (4) step(0, 0, 0, 1'b1, tag);
    check(exp_q.size() == 0 && !out_valid, {tag, " R9 nothing lost"}, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int k = 0; k < NS; k++) begin m_base[k] = 8 * k; m_cnt[k] = 8; m_off[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R9 reset idle", int'({out_valid, in_ready}), 1);
    for (int k = 0; k < NS; k++) begin rd_reg(k, 0, "R1"); rd_reg(k, 1, "R1"); end

    // R2: straight rotation on channel 1, through the wrap
    for (int i = 0; i < 10; i++) step(1, 1, 100 + i, 1'b1, "R2");
    drain("R2");

    // R3: interleaved channels keep separate positions
    for (int i = 0; i < 12; i++) step(1, i % 3, 200 + i, 1'b1, "R3");
    drain("R3");

    // R9: random traffic with random backpressure on default windows
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % NS, $urandom, ($urandom % 3) != 0, "R9");
    drain("R9");

    // R6: window past the top wraps to channel 0
    wr_reg(2, 0, 28);
    rd_reg(2, 0, "R8");
    for (int i = 0; i < 9; i++) step(1, 2, 300 + i, 1'b1, "R6");
    drain("R6");

    // R4: count of zero
    wr_reg(3, 1, 0);
    rd_reg(3, 1, "R4");
    for (int i = 0; i < 4; i++) step(1, 3, 400 + i, i % 2 == 0, "R4");
    drain("R4");

    // R5: oversized count saturates
    wr_reg(0, 1, 50);
    rd_reg(0, 1, "R5");
    for (int i = 0; i < 34; i++) step(1, 0, 500 + i, 1'b1, "R5");
    drain("R5");

    // R7: write restarts only the written channel
    for (int i = 0; i < 3; i++) step(1, 1, 600 + i, 1'b1, "R7");
    step(1, 0, 610, 1'b1, "R7");
    wr_reg(1, 0, m_base[1]);
    step(1, 1, 620, 1'b1, "R7");
    step(1, 0, 621, 1'b1, "R7");
    drain("R7");

    // mixed random configuration and traffic
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 25) == 0) begin
        wr_reg($urandom % NS, $urandom % 2, ($urandom % 2) ? ($urandom % ND) : ($urandom % 41));
      end else if (($urandom % 30) == 0) begin
        rd_reg($urandom % NS, $urandom % 2, "R8");
      end else begin
        step(($urandom % 3) != 0, $urandom % NS, $urandom, ($urandom % 4) != 0, "R2 random");
      end
    end
    drain("R2 random");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule